// File: doc/BRIEF.md
# Frame-Rate-Control Grey Dither Unit

This unit turns a 4-bit grey level into a single on/off bit for a passive LCD pixel. Mid-grey levels are produced by switching the pixel on for a fixed fraction of frames. The sequence of frames has a period of 3, 4, 5 or 7. It is also spread across four neighbouring columns, so adjacent pixels do not flicker in step. Each fraction follows a pattern register: a list of 4-bit words, one for each frame phase, with one bit for each column of a group of four. Reset loads a useful default set into these registers, and they can be rewritten through a simple write port.

A display pipeline gives the unit the level and column of each pixel, in the order they are fetched, and pulses the frame strobe once per frame. The unit has four phase counters, one for each period length. They advance on the frame strobe while the unit runs. The levels with low duty reuse the registers of the complementary high fractions, inverted, so eight registers cover fourteen fractions.

A two-state controller tracks the enable. In `ST_IDLE` the phase counters are held at zero. The transition START (enable high) moves it to `ST_RUN`. In `ST_RUN` the counters advance on each strobe. The transition STOP (enable low) returns it to `ST_IDLE`, and in the same cycle it clears all phases.

Top module: `frc_dither`

## Requirements
- R1: Level 15 always gives an output of 1, and level 0 always gives 0, whatever the phase, the column or the pattern contents.
- R2: Levels 14 down to 7 follow pattern registers 5, 3, 1, 6, 0, 4, 7, 2, which hold the fractions 6/7, 4/5, 3/4, 5/7, 2/3, 3/5, 4/7 and 2/4. The registers with index 0; 1 and 2; 3 and 4; 5 to 7 have pattern lengths of 3, 4, 5 and 7 words.
- R3: For a pattern of length L at phase p, the word used is bits [4(L-1-p)+3 : 4(L-1-p)], so phase 0 takes the most significant used word. Within that word, column c (the low two bits of the column input) selects bit 3-c.
- R4: Levels 6 down to 1 give the bitwise inverse of the bit that registers 7, 4, 0, 6, 3 and 5 would give at the same phase and column. This produces 3/7, 2/5, 1/3, 2/7, 1/5 and 1/7.
- R5: After reset, registers 0 to 7 hold 0x7DA, 0x7DBE, 0xA5A5, 0x7DFBE, 0x7A5AD, 0xFBFDFE7, 0x7B5ADEF and 0xB9DC663.
- R6: A write with the write enable high stores the low 4L bits of the data into the register named by the select input (0 to 7). Outputs registered on the following clock edge use the new pattern.
- R7: Each of the four phase counters (periods 3, 4, 5, 7) starts at 0. In `ST_RUN`, while the enable is high and the strobe is high, each counter advances by one on the clock edge, and after L-1 it wraps to 0. Without a strobe the counters hold.
- R8: While the enable is low, all phases are 0. Strobes while the enable is low are ignored, and so is a strobe in the first cycle of a high enable (`ST_IDLE`).
- R9: The output is registered. It reflects the level, column and phases present at the previous clock edge, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Unit enable; low clears the frame phases |
| frame_strobe_i | input | 1 | One-cycle pulse per frame |
| level_i | input | 4 | Grey level of the current pixel |
| column_i | input | COL_W | Column of the current pixel (low two bits used) |
| cfg_we_i | input | 1 | Pattern register write enable |
| cfg_sel_i | input | 3 | Pattern register index |
| cfg_data_i | input | 28 | Pattern register write data |
| pix_o | output | 1 | Dithered on/off pixel |

## Verification
A pixel result appears one clock after its level and column are applied, through the single output register. A pattern write, a strobe or a change of enable acts on the result computed at the next edge. The bench drives all inputs on falling edges and compares `pix_o` on the falling edge that follows. It never changes the strobe in a cycle whose result it checks. It keeps its own frame count, reduces that count modulo each period, and sweeps all levels and columns over every phase combination (420 frames).

// File: rtl/dither_pkg.sv
package dither_pkg;

    localparam int NPAT  = 8;   // pattern registers
    localparam int NPER  = 4;   // distinct period lengths
    localparam int PAT_W = 28;  // widest pattern: 7 words of 4 bits
    localparam int PH_W  = 3;   // phase counter width (max period 7)
    localparam int SEL_W = $clog2(NPAT);

    localparam int PER_LEN [NPER] = '{3, 4, 5, 7};

    typedef logic [PAT_W-1:0] pat_t;
    typedef logic [PH_W-1:0]  ph_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // How a grey level is produced.
    typedef struct packed {
        logic             use_pat;
        logic             konst;
        logic             inv;
        logic [SEL_W-1:0] src;
    } lvl_map_t;

    // Period slot used by each pattern register.
    function automatic int pat_per(input int k);
        case (k)
            0:       return 0;
            1, 2:    return 1;
            3, 4:    return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int pat_len(input int k);
        return PER_LEN[pat_per(k)];
    endfunction

    function automatic pat_t len_mask(input int k);
        pat_t m;
        m = '0;
        for (int i = 0; i < PAT_W; i++)
            if (i < 4 * pat_len(k)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic pat_t default_pattern(input int k);
        case (k)
            0:       return 28'h00007DA;
            1:       return 28'h0007DBE;
            2:       return 28'h000A5A5;
            3:       return 28'h007DFBE;
            4:       return 28'h007A5AD;
            5:       return 28'hFBFDFE7;
            6:       return 28'h7B5ADEF;
            default: return 28'hB9DC663;
        endcase
    endfunction

    function automatic lvl_map_t level_map(input logic [3:0] lvl);
        lvl_map_t m;
        m = '{use_pat: 1'b1, konst: 1'b0, inv: 1'b0, src: '0};
        case (lvl)
            4'd15: begin m.use_pat = 1'b0; m.konst = 1'b1; end
            4'd14: m.src = 3'd5;
            4'd13: m.src = 3'd3;
            4'd12: m.src = 3'd1;
            4'd11: m.src = 3'd6;
            4'd10: m.src = 3'd0;
            4'd9:  m.src = 3'd4;
            4'd8:  m.src = 3'd7;
            4'd7:  m.src = 3'd2;
            4'd6:  begin m.src = 3'd7; m.inv = 1'b1; end
            4'd5:  begin m.src = 3'd4; m.inv = 1'b1; end
            4'd4:  begin m.src = 3'd0; m.inv = 1'b1; end
            4'd3:  begin m.src = 3'd6; m.inv = 1'b1; end
            4'd2:  begin m.src = 3'd3; m.inv = 1'b1; end
            4'd1:  begin m.src = 3'd5; m.inv = 1'b1; end
            default: begin m.use_pat = 1'b0; m.konst = 1'b0; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dither_phase.sv
module dither_phase
    import dither_pkg::*;
#(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    output ph_t  ph_o
);
    localparam ph_t LAST = PH_W'(LEN - 1);

    ph_t ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ph_q <= '0;
        end else if (adv_i) begin
            ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
        end
    end

    assign ph_o = ph_q;
endmodule

// File: rtl/dither_patregs.sv
module dither_patregs
    import dither_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [SEL_W-1:0]            sel_i,
    input  pat_t                        data_i,
    output logic [NPAT-1:0][PAT_W-1:0]  pats_o
);
    logic [NPAT-1:0][PAT_W-1:0] pats_q;

    for (genvar k = 0; k < NPAT; k++) begin : g_reg
        localparam pat_t MASK = len_mask(k);
        localparam pat_t INIT = default_pattern(k);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pats_q[k] <= INIT;
            end else if (we_i && (sel_i == SEL_W'(k))) begin
                pats_q[k] <= data_i & MASK;
            end
        end
    end

    assign pats_o = pats_q;
endmodule

// File: rtl/dither_pick.sv
module dither_pick
    import dither_pkg::*;
(
    input  logic [3:0]                  level_i,
    input  logic [1:0]                  col_i,
    input  logic [NPAT-1:0][PAT_W-1:0]  pats_i,
    input  logic [NPER-1:0][PH_W-1:0]   phs_i,
    output logic                        on_o
);
    lvl_map_t   map;
    pat_t       pat;
    ph_t        ph;
    logic [4:0] bit_idx;
    int         len;

    always_comb begin
        map     = level_map(level_i);
        pat     = pats_i[map.src];
        len     = pat_len(int'(map.src));
        ph      = phs_i[pat_per(int'(map.src))];
        // phase 0 lives in the top used word; column 0 in bit 3 of a word
        bit_idx = 5'((len - 1 - int'(ph)) * 4 + 3 - int'(col_i));
        if (map.use_pat) on_o = pat[bit_idx] ^ map.inv;
        else             on_o = map.konst;
    end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
    import dither_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              frame_strobe_i,
    input  logic [3:0]        level_i,
    input  logic [COL_W-1:0]  column_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [27:0]       cfg_data_i,
    output logic              pix_o
);
    run_state_e state_q, state_d;
    logic       run_w;
    logic       adv_w;
    logic       on_w;
    logic       pix_q;

    logic [NPAT-1:0][PAT_W-1:0] pats;
    logic [NPER-1:0][PH_W-1:0]  phs;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START (IDLE->RUN), STOP (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable_i)  state_d = ST_RUN;
            ST_RUN:  if (!enable_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign run_w = (state_q == ST_RUN);
    assign adv_w = run_w && enable_i && frame_strobe_i;

    for (genvar g = 0; g < NPER; g++) begin : g_ph
        dither_phase #(.LEN(PER_LEN[g])) u_ph (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (!enable_i),
            .adv_i (adv_w),
            .ph_o  (phs[g])
        );
    end

    dither_patregs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .sel_i  (cfg_sel_i),
        .data_i (cfg_data_i),
        .pats_o (pats)
    );

    dither_pick u_pick (
        .level_i (level_i),
        .col_i   (column_i[1:0]),
        .pats_i  (pats),
        .phs_i   (phs),
        .on_o    (on_w)
    );

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= 1'b0;
        else        pix_q <= on_w;
    end

    assign pix_o = pix_q;
endmodule

// File: rtl/dither_chk.sv
module dither_chk
    import dither_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable_i,
    input logic                       frame_strobe_i,
    input logic [3:0]                 level_i,
    input logic                       pix_o,
    input logic                       run_w,
    input logic [NPER-1:0][PH_W-1:0]  phs
);
    assert_full_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == 4'd15) |=> pix_o);

    assert_full_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == 4'd0) |=> !pix_o);

    assert_clear_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (phs == '0));

    assert_first_strobe_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && enable_i && frame_strobe_i) |=> (phs == '0));

    assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !frame_strobe_i) |=> $stable(phs));

    assert_wrap_seven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && enable_i && frame_strobe_i && phs[3] == 3'd6) |=> (phs[3] == 3'd0));

    assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phs[0] < 3'd3) && (phs[1] < 3'd4) && (phs[2] < 3'd5) && (phs[3] < 3'd7));
endmodule

bind frc_dither dither_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .frame_strobe_i (frame_strobe_i),
    .level_i        (level_i),
    .pix_o          (pix_o),
    .run_w          (run_w),
    .phs            (phs)
);

// File: tb/tb_frc_dither.sv
`timescale 1ns/1ps
module tb_frc_dither;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             strobe = 1'b0;
    logic [3:0]       level = 4'd15;
    logic [COL_W-1:0] column = '0;
    logic             we = 1'b0;
    logic [2:0]       sel = '0;
    logic [27:0]      data = '0;
    logic             pix;

    int checks = 0;
    int failures = 0;
    int frame = 0;
    bit done = 0;

    int unsigned mpat [8] = '{32'h7DA, 32'h7DBE, 32'hA5A5, 32'h7DFBE,
                              32'h7A5AD, 32'hFBFDFE7, 32'h7B5ADEF, 32'hB9DC663};
    int mlen [8] = '{3, 4, 4, 5, 5, 7, 7, 7};

    always #2 clk = ~clk;

    frc_dither #(.COL_W(COL_W)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable_i       (enable),
        .frame_strobe_i (strobe),
        .level_i        (level),
        .column_i       (column),
        .cfg_we_i       (we),
        .cfg_sel_i      (sel),
        .cfg_data_i     (data),
        .pix_o          (pix)
    );

    // R2/R4 mapping, R3 word/bit selection
    function automatic bit expect_on(int lvl, int col, int f);
        int k; bit inv; int len; int ph; int sh;
        inv = 0; k = 0;
        case (lvl)
            15: return 1'b1;
            0:  return 1'b0;
            14: k = 5; 13: k = 3; 12: k = 1; 11: k = 6;
            10: k = 0; 9:  k = 4; 8:  k = 7; 7:  k = 2;
            6: begin k = 7; inv = 1; end
            5: begin k = 4; inv = 1; end
            4: begin k = 0; inv = 1; end
            3: begin k = 6; inv = 1; end
            2: begin k = 3; inv = 1; end
            default: begin k = 5; inv = 1; end
        endcase
        len = mlen[k];
        ph  = f % len;
        sh  = (len - 1 - ph) * 4 + (3 - col);
        return bit'((mpat[k] >> sh) & 1) ^ inv;
    endfunction

    task automatic check(bit got, bit exp, string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0b exp=%0b time=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic run_frames(int n, string base);
        for (int fr = 0; fr < n; fr++) begin
            for (int lvl = 0; lvl < 16; lvl++) begin
                for (int col = 0; col < 4; col++) begin
                    string lt;
                    lt = (lvl == 0 || lvl == 15) ? "R1" : (lvl >= 7 ? "R2" : "R4");
                    level  = 4'(lvl);
                    column = COL_W'(col + 4 * (fr % 5));
                    @(negedge clk);
                    check(pix, expect_on(lvl, col, frame),
                          $sformatf("%s %s R3 R7 R9 lvl=%0d col=%0d frame=%0d",
                                    base, lt, lvl, col, frame));
                end
            end
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            frame++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // reset state (R9)
        @(negedge clk);
        @(negedge clk);
        check(pix, 1'b0, "R9 reset output");
        @(negedge clk);
        rst_n = 1'b1;

        // start and sweep all phase combinations with defaults (R5)
        enable = 1'b1;
        @(negedge clk);
        frame = 0;
        run_frames(420, "R5");

        // move phases, then disable with strobes that must be ignored (R8)
        strobe = 1'b1; @(negedge clk);
        @(negedge clk);
        strobe = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        strobe = 1'b1; @(negedge clk);
        strobe = 1'b0; @(negedge clk);
        enable = 1'b1;
        strobe = 1'b1;          // first cycle of enable: ignored
        @(negedge clk);
        strobe = 1'b0;
        frame = 0;
        run_frames(7, "R8");

        // reprogram every pattern (R6)
        for (int k = 0; k < 8; k++) begin
            int unsigned v;
            v = (32'h9E3779B9 * (k + 1)) ^ (32'h5A5A5A5A >> k);
            we   = 1'b1;
            sel  = 3'(k);
            data = v[27:0];
            @(negedge clk);
            mpat[k] = v & ((32'h1 << (4 * mlen[k])) - 1);
        end
        we = 1'b0;
        run_frames(70, "R6");

        finish_run();
    end
endmodule